// File: doc/BRIEF.md
# Suspend-Aware Programmable Clock Output

This block holds a 16-bit configuration word and uses it to drive a programmable clock pin. The clock is divided from the device reference. A host loads the word with one command code and reads it back with another. Each transfer moves two bytes, low byte first, over a byte-wide strobe port.

The output runs at 48/(N+1) MHz, where N is the 4-bit division factor in bits 11:8. The block is clocked at twice the 48 MHz reference (96 MHz), so every divided output has a 50 % duty cycle, including odd ratios. A new N takes effect only at the end of a full output period.

When the suspend request input is held, a delay timer of about 2 ms starts. When the timer expires, two control bits decide what the pin does: switch to a slow low-power clock, keep the divided clock, or go quiet. The slow clock arrives as a qualified tick input, and each tick toggles the slow level. Source changes pass through a two-stage handover that only moves while the sources involved are low. A status output shows whether the internal clock is still running. Only the power-on reset input restores the configuration defaults.

Top module: `clkout_ctrl`

## Requirements
- R1: After rstN is released, the configuration word is 16'h2340, clkOut is low, clkRunning is high and rdData is 0. The output divides by the reset factor N=3.
- R2: Command 8'hBA followed by two write strobes loads the low byte, then the high byte. The whole word changes on the second strobe. The data bit for bit 15 is discarded and stored as 0.
- R3: Command 8'hBB followed by two read strobes puts the low byte, then the high byte, on rdData, each one cycle after its strobe. Bit 15 reads as 0.
- R4: A write or read strobe outside an open transfer of the matching kind leaves both the configuration word and rdData unchanged. This covers strobes after a finished transfer and strobes after any other command code.
- R5: With the divided clock selected, every high phase and every low phase of clkOut lasts exactly N+1 cycles of clk.
- R6: A new N is loaded only when clkOut falls. While the change is pending, every phase lasts either the old N+1 or the new N+1 cycles.
- R7: With suspReq held high and bit 12 at 0, clkRunning goes low exactly 2*SUSP_REF_CYC clk cycles after suspReq is first sampled high.
- R8: Dropping suspReq before the delay expires cancels the switch: clkRunning stays high and the divided clock continues. A later request restarts the full delay.
- R9: After the delay with bit 13 at 0, clkOut carries the slow clock: each phase equals the tick spacing, and clkRunning follows bit 12.
- R10: After the delay with bit 13 at 1, clkOut keeps the divided clock if bit 12 is 1, and is held low if bit 12 is 0.
- R11: No high pulse on clkOut, including across a source change, is shorter than the shorter high phase of the two sources.
- R12: Once suspReq drops after the delay, clkOut returns to the divided clock and clkRunning returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 96 MHz clock, twice the 48 MHz reference |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| hostCmdStb | input | 1 | hostData carries a command code |
| hostWrStb | input | 1 | hostData carries a write byte |
| hostRdStb | input | 1 | Request the next read byte |
| hostData | input | 8 | Command code or write byte |
| rdData | output | 8 | Read byte, valid one cycle after hostRdStb |
| suspReq | input | 1 | Suspend request level |
| slowTick | input | 1 | Qualified tick of the slow clock; each tick toggles its level |
| clkOut | output | 1 | Programmable clock output (registered) |
| clkRunning | output | 1 | High while the internal clock is kept running |

## Verification
The timing rules are as follows:
- rdData and the stored word are due one clk cycle after their strobe.
- clkRunning falls exactly 2*SUSP_REF_CYC cycles after the first sampled suspend request.
- Phase lengths are counted in whole clk cycles between output transitions.

The bench drives inputs on falling clk edges and samples on those same edges before it drives. This puts every result at a fixed count of rising edges after its stimulus. For the suspend delay, the bench counts that exact number of edges and checks the status both one cycle before and at the expiry edge. Source changes do not settle in a fixed number of cycles, because they depend on the phases of the two sources. For those cases, the bench waits a bound longer than the worst-case handover and then measures complete phases.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  localparam int DIV_W        = 4;
  localparam int DIV_LSB      = 8;
  localparam int RUN_KEEP_BIT = 12;
  localparam int SLOW_OFF_BIT = 13;
  localparam int RSVD_BIT     = 15;
  localparam logic [7:0] CMD_WRITE = 8'hBA;
  localparam logic [7:0] CMD_READ  = 8'hBB;

  typedef enum logic [1:0] {SRC_DIV = 2'd0, SRC_SLOW = 2'd1, SRC_OFF = 2'd2} clk_src_e;
  typedef enum logic [1:0] {XF_IDLE = 2'd0, XF_WR = 2'd1, XF_RD = 2'd2} xfer_e;

  typedef struct packed {
    logic [DIV_W-1:0] divN;
    clk_src_e         srcTarget;
  } ctl_strobe_t;
endpackage

// File: rtl/clkout_cfg_ctl.sv
module clkout_cfg_ctl
  import clkout_pkg::*;
#(
  parameter int          SUSP_REF_CYC = 96000,
  parameter logic [15:0] CFG_RESET    = 16'h2340
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostCmdStb,
  input  logic        hostWrStb,
  input  logic        hostRdStb,
  input  logic [7:0]  hostData,
  input  logic        suspReq,
  output logic [7:0]  rdData,
  output logic        clkRunning,
  output ctl_strobe_t ctlStb
);
  localparam int DELAY_CYC = 2 * SUSP_REF_CYC;
  localparam int CNT_W     = $clog2(DELAY_CYC + 1);

  logic [15:0] cfgReg;
  logic [7:0]  lowShadow;
  xfer_e       xferMode;
  logic        byteSel;
  logic [CNT_W-1:0] suspCnt;
  logic        elapsedQ;

  // Host command decoding and the configuration word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg    <= CFG_RESET & ~(16'd1 << RSVD_BIT);
      lowShadow <= '0;
      xferMode  <= XF_IDLE;
      byteSel   <= 1'b0;
      rdData    <= '0;
    end else if (hostCmdStb) begin
      byteSel <= 1'b0;
      if (hostData == CMD_WRITE)     xferMode <= XF_WR;
      else if (hostData == CMD_READ) xferMode <= XF_RD;
      else                           xferMode <= XF_IDLE;
    end else if (hostWrStb && xferMode == XF_WR) begin
      if (!byteSel) begin
        lowShadow <= hostData;
        byteSel   <= 1'b1;
      end else begin
        cfgReg   <= {1'b0, hostData[6:0], lowShadow};
        byteSel  <= 1'b0;
        xferMode <= XF_IDLE;
      end
    end else if (hostRdStb && xferMode == XF_RD) begin
      rdData  <= byteSel ? cfgReg[15:8] : cfgReg[7:0];
      byteSel <= ~byteSel;
      if (byteSel) xferMode <= XF_IDLE;
    end
  end

  // Suspend delay timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      suspCnt  <= '0;
      elapsedQ <= 1'b0;
    end else if (!suspReq) begin
      suspCnt  <= '0;
      elapsedQ <= 1'b0;
    end else if (!elapsedQ) begin
      if (suspCnt == CNT_W'(DELAY_CYC - 1)) elapsedQ <= 1'b1;
      else                                   suspCnt  <= suspCnt + 1'b1;
    end
  end

  always_comb begin
    ctlStb.divN = cfgReg[DIV_LSB +: DIV_W];
    if (!elapsedQ)                 ctlStb.srcTarget = SRC_DIV;
    else if (!cfgReg[SLOW_OFF_BIT]) ctlStb.srcTarget = SRC_SLOW;
    else if (cfgReg[RUN_KEEP_BIT])  ctlStb.srcTarget = SRC_DIV;
    else                            ctlStb.srcTarget = SRC_OFF;
  end

  assign clkRunning = ~(elapsedQ & ~cfgReg[RUN_KEEP_BIT]);

  // R2
  cfg_write_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgReg) |-> $past(hostWrStb));
  // R7
  delay_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(elapsedQ) |-> $past(suspReq));
  // R8
  cancel_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !suspReq |=> !elapsedQ);
endmodule

// File: rtl/clkout_div_path.sv
module clkout_div_path
  import clkout_pkg::*;
#(
  parameter logic [DIV_W-1:0] RESET_DIV = 4'd3
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctl_strobe_t ctlStb,
  input  logic        slowTick,
  output logic        clkOut
);
  logic [DIV_W-1:0] activeN;
  logic [DIV_W-1:0] halfCnt;
  logic divQ, slowQ, enDiv, enSlow;
  logic divNext, slowNext, enDivNext, enSlowNext, wrapNow;

  always_comb begin
    wrapNow    = (halfCnt == activeN);
    divNext    = wrapNow ? ~divQ : divQ;
    slowNext   = slowTick ? ~slowQ : slowQ;
    enDivNext  = enDiv;
    enSlowNext = enSlow;
    // each enable moves only while its own source is low after this edge,
    // and a source is enabled only once the other one is released
    if (!divNext)  enDivNext  = (ctlStb.srcTarget == SRC_DIV)  && !enSlow;
    if (!slowNext) enSlowNext = (ctlStb.srcTarget == SRC_SLOW) && !enDiv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeN <= RESET_DIV;
      halfCnt <= '0;
      divQ    <= 1'b0;
      slowQ   <= 1'b0;
      enDiv   <= 1'b1;
      enSlow  <= 1'b0;
      clkOut  <= 1'b0;
    end else begin
      if (wrapNow) begin
        halfCnt <= '0;
        if (divQ) activeN <= ctlStb.divN;
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
      divQ   <= divNext;
      slowQ  <= slowNext;
      enDiv  <= enDivNext;
      enSlow <= enSlowNext;
      clkOut <= (divNext & enDivNext) | (slowNext & enSlowNext);
    end
  end

  // R6
  div_load_at_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeN) |-> $fell(divQ));
  // R11
  src_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(enDiv && enSlow));
  // R11
  div_gate_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(enDiv) |-> !divQ);
  // R11
  slow_gate_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(enSlow) |-> !slowQ);
endmodule

// File: rtl/clkout_ctrl.sv
module clkout_ctrl
  import clkout_pkg::*;
#(
  parameter int          SUSP_REF_CYC = 96000,
  parameter logic [15:0] CFG_RESET    = 16'h2340
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostCmdStb,
  input  logic       hostWrStb,
  input  logic       hostRdStb,
  input  logic [7:0] hostData,
  output logic [7:0] rdData,
  input  logic       suspReq,
  input  logic       slowTick,
  output logic       clkOut,
  output logic       clkRunning
);
  localparam logic [DIV_W-1:0] RESET_DIV = CFG_RESET[DIV_LSB +: DIV_W];

  ctl_strobe_t ctlStb;

  clkout_cfg_ctl #(.SUSP_REF_CYC(SUSP_REF_CYC), .CFG_RESET(CFG_RESET)) i_ctl (
    .clk(clk), .rstN(rstN), .hostCmdStb(hostCmdStb), .hostWrStb(hostWrStb),
    .hostRdStb(hostRdStb), .hostData(hostData), .suspReq(suspReq),
    .rdData(rdData), .clkRunning(clkRunning), .ctlStb(ctlStb));

  clkout_div_path #(.RESET_DIV(RESET_DIV)) i_dp (
    .clk(clk), .rstN(rstN), .ctlStb(ctlStb), .slowTick(slowTick), .clkOut(clkOut));
endmodule

// File: tb/test_clkout_ctrl.sv
module test_clkout_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SUSP_REF   = 40;
  localparam int DELAY      = 2 * SUSP_REF;
  localparam int SLOW_GAP   = 9;

  logic clk = 1'b0, rstN = 1'b0;
  logic hostCmdStb = 1'b0, hostWrStb = 1'b0, hostRdStb = 1'b0;
  logic [7:0] hostData = '0;
  logic suspReq = 1'b0, slowTick = 1'b0;
  logic [7:0] rdData;
  logic clkOut, clkRunning;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  clkout_ctrl #(.SUSP_REF_CYC(SUSP_REF)) i_clkout_ctrl (
    .clk(clk), .rstN(rstN), .hostCmdStb(hostCmdStb), .hostWrStb(hostWrStb),
    .hostRdStb(hostRdStb), .hostData(hostData), .rdData(rdData),
    .suspReq(suspReq), .slowTick(slowTick), .clkOut(clkOut), .clkRunning(clkRunning));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      repeat (SLOW_GAP - 1) @(negedge clk);
      slowTick = 1'b1;
      @(negedge clk);
      slowTick = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
    end
  end

  task automatic sendCmd(input logic [7:0] c);
    hostCmdStb = 1'b1; hostData = c; @(negedge clk); hostCmdStb = 1'b0;
  endtask
  task automatic sendByte(input logic [7:0] b);
    hostWrStb = 1'b1; hostData = b; @(negedge clk); hostWrStb = 1'b0;
  endtask
  task automatic pullByte(output logic [7:0] b);
    hostRdStb = 1'b1; @(negedge clk); hostRdStb = 1'b0; b = rdData;
  endtask
  task automatic writeCfg(input logic [15:0] w);
    sendCmd(8'hBA); sendByte(w[7:0]); sendByte(w[15:8]);
  endtask
  task automatic readCfg(output logic [15:0] w);
    logic [7:0] lo, hi;
    sendCmd(8'hBB); pullByte(lo); pullByte(hi); w = {hi, lo};
  endtask

  // measure complete phases of clkOut, skipping the first partial one
  task automatic measureRuns(input int nRuns, output int minHi, output int maxHi,
                             output int minLo, output int maxLo);
    logic prev; int len; int got; bit first;
    minHi = 9999; maxHi = 0; minLo = 9999; maxLo = 0;
    got = 0; first = 1'b1; len = 1;
    @(negedge clk); prev = clkOut;
    while (got < nRuns) begin
      @(negedge clk);
      if (clkOut == prev) len++;
      else begin
        if (!first) begin
          if (prev) begin if (len < minHi) minHi = len; if (len > maxHi) maxHi = len; end
          else      begin if (len < minLo) minLo = len; if (len > maxLo) maxLo = len; end
          got++;
        end
        first = 1'b0; len = 1; prev = clkOut;
      end
    end
  endtask

  task automatic testReset();
    logic [15:0] w;
    chk(clkOut == 1'b0, "R1", "clkOut after reset", clkOut, 0);
    chk(clkRunning == 1'b1, "R1", "clkRunning after reset", clkRunning, 1);
    chk(rdData == 8'h00, "R1", "rdData after reset", rdData, 0);
    readCfg(w);
    chk(w == 16'h2340, "R1", "reset word", w, 16'h2340);
  endtask

  task automatic testDivide(input int n);
    int a, b, c, d;
    writeCfg(16'h2040 | 16'(n << 8));
    repeat (70) @(negedge clk);
    measureRuns(6, a, b, c, d);
    chk(a == n + 1 && b == n + 1, "R5", $sformatf("high phase N=%0d", n), a, n + 1);
    chk(c == n + 1 && d == n + 1, "R5", $sformatf("low phase N=%0d", n), d, n + 1);
  endtask

  task automatic testWriteRead();
    logic [15:0] w;
    writeCfg(16'hF3A5);
    readCfg(w);
    chk(w == 16'h73A5, "R2", "write with bit 15 set", w, 16'h73A5);
    chk(w[15] == 1'b0, "R3", "reserved reads 0", w[15], 0);
    sendCmd(8'hBA); sendByte(8'h11);
    readCfg(w);
    chk(w == 16'h73A5, "R2", "half write does not commit", w, 16'h73A5);
    writeCfg(16'h2340);
  endtask

  task automatic testIgnored();
    logic [15:0] w; logic [7:0] keep;
    sendByte(8'hFF); sendByte(8'hFF);
    sendCmd(8'h55); sendByte(8'h00); sendByte(8'h00);
    readCfg(w);
    chk(w == 16'h2340, "R4", "stray write strobes", w, 16'h2340);
    keep = rdData;
    hostRdStb = 1'b1; @(negedge clk); hostRdStb = 1'b0;
    chk(rdData == keep, "R4", "stray read strobe", rdData, keep);
    sendCmd(8'hBA); hostRdStb = 1'b1; @(negedge clk); hostRdStb = 1'b0;
    chk(rdData == keep, "R4", "read during write transfer", rdData, keep);
    sendCmd(8'h00);
  endtask

  task automatic testChange();
    int a, b, c, d;
    writeCfg(16'h2340);
    repeat (40) @(negedge clk);
    writeCfg(16'h2940);
    measureRuns(10, a, b, c, d);
    chk((a == 4 || a == 10) && (b == 4 || b == 10), "R6", "high phases during change", a, 10);
    chk((c == 4 || c == 10) && (d == 4 || d == 10), "R6", "low phases during change", c, 10);
    measureRuns(4, a, b, c, d);
    chk(a == 10 && d == 10, "R6", "settled on new N", a, 10);
    writeCfg(16'h2340);
    repeat (40) @(negedge clk);
  endtask

  task automatic testDelay();
    writeCfg(16'h2340);
    suspReq = 1'b1;
    repeat (DELAY - 1) @(negedge clk);
    chk(clkRunning == 1'b1, "R7", "running one cycle before expiry", clkRunning, 1);
    @(negedge clk);
    chk(clkRunning == 1'b0, "R7", "stopped at expiry", clkRunning, 0);
    suspReq = 1'b0;
    @(negedge clk);
    chk(clkRunning == 1'b1, "R12", "running after release", clkRunning, 1);
    repeat (40) @(negedge clk);
  endtask

  task automatic testCancel();
    int a, b, c, d;
    suspReq = 1'b1;
    repeat (DELAY - 2) @(negedge clk);
    suspReq = 1'b0;
    @(negedge clk);
    suspReq = 1'b1;
    repeat (DELAY - 1) @(negedge clk);
    chk(clkRunning == 1'b1, "R8", "restarted delay not expired", clkRunning, 1);
    suspReq = 1'b0;
    measureRuns(4, a, b, c, d);
    chk(a == 4 && d == 4, "R8", "divided clock kept", a, 4);
  endtask

  task automatic testSlow();
    int a, b, c, d;
    writeCfg(16'h0340);
    suspReq = 1'b1;
    measureRuns(30, a, b, c, d);
    chk(a >= 4, "R11", "no short high across switch to slow", a, 4);
    repeat (40) @(negedge clk);
    measureRuns(4, a, b, c, d);
    chk(a == SLOW_GAP && b == SLOW_GAP, "R9", "slow high phase", a, SLOW_GAP);
    chk(c == SLOW_GAP && d == SLOW_GAP, "R9", "slow low phase", c, SLOW_GAP);
    chk(clkRunning == 1'b0, "R9", "clkRunning with bit 12 low", clkRunning, 0);
    suspReq = 1'b0;
    measureRuns(8, a, b, c, d);
    chk(a >= 4, "R11", "no short high across switch back", a, 4);
    repeat (40) @(negedge clk);
    measureRuns(4, a, b, c, d);
    chk(a == 4 && d == 4, "R12", "divided clock after resume", a, 4);
    chk(clkRunning == 1'b1, "R12", "clkRunning after resume", clkRunning, 1);
  endtask

  task automatic testKeepAndStop();
    int a, b, c, d; int highs;
    writeCfg(16'h3340);
    suspReq = 1'b1;
    repeat (DELAY + 40) @(negedge clk);
    measureRuns(4, a, b, c, d);
    chk(a == 4 && d == 4, "R10", "divided clock kept with bit 12 high", a, 4);
    chk(clkRunning == 1'b1, "R10", "running with bit 12 high", clkRunning, 1);
    suspReq = 1'b0;
    writeCfg(16'h2340);
    repeat (20) @(negedge clk);
    suspReq = 1'b1;
    repeat (DELAY + 40) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (clkOut) highs++;
    end
    chk(highs == 0, "R10", "output held low", highs, 0);
    suspReq = 1'b0;
    repeat (40) @(negedge clk);
    measureRuns(4, a, b, c, d);
    chk(a == 4 && d == 4, "R12", "resume from stopped", a, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWriteRead();
    testIgnored();
    testDivide(0);
    testDivide(1);
    testDivide(6);
    testDivide(15);
    testDivide(3);
    testChange();
    testDelay();
    testCancel();
    testSlow();
    testKeepAndStop();
    done = 1'b1;
    summary();
  end
endmodule